// File: doc/BRIEF.md
# Shared-Memory Twin Address Port Unit

This unit places two access ports on one byte-wide RAM with 8-bit addresses. The left port is for data. Its address comes from a loadable address counter. It writes the byte that sits on the shared input bus, and it can drive the addressed byte onto the bus output. The right port is for instruction fetch and is read-only. Its address comes from a second, independent loadable counter, called the fetch pointer. The port always presents the byte at that pointer.

The bus is time-shared between address and data. In one cycle the bus value is loaded into one of the counters. In a later cycle the data moves to or from the addressed location. Either counter can also post-increment, so a string of bytes can be read or written with no further address loads.

Every transfer takes one clock and the unit never stalls. No transfer has a valid/ready handshake. A strobe sampled high at a rising edge is always accepted, and a read port's data is valid in the same cycle as its strobe or pointer. A consumer that needs to hold off simply leaves the strobes low.

Top module: `twin_port_mem`

## Requirements
- R1: Driving `clr_n` low sets both address counters to 00h immediately, with no clock edge needed.
- R2: At a rising edge with `bus_src_en`=1, `ar_load`=1 loads `bus_in` into the data address counter, and `pc_load`=1 loads `bus_in` into the fetch pointer.
- R3: A load strobe has no effect while `bus_src_en`=0. The counter keeps its value, as seen on `ar_addr` or `pc_addr`.
- R4: At a rising edge with `mem_wr`=1, `bus_in` is written to the location given by the data address counter.
- R5: While `rd_en`=1, `bus_out` shows the byte at the data address counter. While `rd_en`=0, `bus_out` is 00h.
- R6: `ins` always shows the byte at the fetch pointer. The right port has no way to write.
- R7: `ar_step`=1 adds one to the data address counter at a rising edge, and `pc_step`=1 does the same for the fetch pointer. Both counters wrap from FFh to 00h.
- R8: If a valid load and a step reach the same counter in the same cycle, the load wins and the step is dropped.
- R9: If the left port writes the location that the fetch pointer addresses, `ins` shows the old byte up to the write edge and the new byte after it.
- R10: A write issued together with `ar_step` goes to the address held before the increment.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising-edge active |
| clr_n | input | 1 | Active-low asynchronous clear of both counters |
| bus_in | input | 8 | Shared bus value: an address or write data |
| bus_src_en | input | 1 | Qualifies the bus value as a load source |
| ar_load | input | 1 | Load the data address counter from the bus |
| pc_load | input | 1 | Load the fetch pointer from the bus |
| ar_step | input | 1 | Post-increment the data address counter |
| pc_step | input | 1 | Post-increment the fetch pointer |
| mem_wr | input | 1 | Write the bus value at the data address |
| rd_en | input | 1 | Drive the byte at the data address onto `bus_out` |
| bus_out | output | 8 | Left-port read data |
| ins | output | 8 | Right-port instruction byte |
| ar_addr | output | 8 | Current data address |
| pc_addr | output | 8 | Current fetch pointer |

## Verification
The embedded assertions check, on every cycle, the next value of each counter: load, increment with wrap, hold, and the priority of load over step. They also check that a write lands at the pre-increment address, and that `bus_out` is idle while the left read is disabled.

Only the directed scenarios can show the end-to-end behaviour. These include the address-then-data sequence across both ports, the old-then-new view of a location being overwritten under the fetch pointer, streamed reads through both counters, and an immediate clear arriving between clock edges.

// File: rtl/twin_port_pkg.sv
package twin_port_pkg;
  localparam int unsigned ADDR_W = 8;
  localparam int unsigned DATA_W = 8;
  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [DATA_W-1:0] data_t;
  typedef struct packed {
    logic load;
    logic step;
  } cnt_ctl_t;
endpackage

// File: rtl/addr_counter.sv
module addr_counter #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             clr_n,
  input  logic             load,
  input  logic             step,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] q
);
  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n)     q <= '0;
    else if (load)  q <= din;      // load outranks step
    else if (step)  q <= q + ONE;  // natural wrap at the top
  end

  // R2: a load takes the input value
  p_load_r2: assert property (@(posedge clk) disable iff (!clr_n)
    load |=> q == $past(din));
  // R7, R8: a step without a load increments with wrap
  p_step_r7: assert property (@(posedge clk) disable iff (!clr_n)
    (step && !load) |=> q == WIDTH'($past(q) + ONE));
  // R3: no strobe means hold
  p_hold_r3: assert property (@(posedge clk) disable iff (!clr_n)
    (!step && !load) |=> $stable(q));
endmodule

// File: rtl/mem_core.sv
module mem_core #(
  parameter int unsigned AW = 8,
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] left_addr,
  input  logic [AW-1:0] right_addr,
  output logic [DW-1:0] left_data,
  output logic [DW-1:0] right_data
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) cells[wr_addr] <= wr_data;
  end

  // combinational reads: the right port sees old data until the write edge
  assign left_data  = cells[left_addr];
  assign right_data = cells[right_addr];

  // R4, R10: written byte lands at the address present at the edge
  p_write_r4: assert property (@(posedge clk)
    wr_en |=> cells[$past(wr_addr)] == $past(wr_data));
endmodule

// File: rtl/twin_port_mem.sv
module twin_port_mem
  import twin_port_pkg::*;
(
  input  logic       clk,
  input  logic       clr_n,
  input  logic [7:0] bus_in,
  input  logic       bus_src_en,
  input  logic       ar_load,
  input  logic       pc_load,
  input  logic       ar_step,
  input  logic       pc_step,
  input  logic       mem_wr,
  input  logic       rd_en,
  output logic [7:0] bus_out,
  output logic [7:0] ins,
  output logic [7:0] ar_addr,
  output logic [7:0] pc_addr
);
  localparam int unsigned NPORT = 2;  // index 0: data port, 1: fetch port

  cnt_ctl_t ctl   [NPORT];
  addr_t    cnt_q [NPORT];
  data_t    left_rd;

  always_comb begin
    ctl[0].load = bus_src_en & ar_load;
    ctl[0].step = ar_step;
    ctl[1].load = bus_src_en & pc_load;
    ctl[1].step = pc_step;
  end

  for (genvar g = 0; g < NPORT; g++) begin : g_cnt
    addr_counter #(.WIDTH(ADDR_W)) u_cnt (
      .clk   (clk),
      .clr_n (clr_n),
      .load  (ctl[g].load),
      .step  (ctl[g].step),
      .din   (bus_in),
      .q     (cnt_q[g])
    );
  end

  mem_core #(.AW(ADDR_W), .DW(DATA_W)) u_mem (
    .clk        (clk),
    .wr_en      (mem_wr),
    .wr_addr    (cnt_q[0]),
    .wr_data    (bus_in),
    .left_addr  (cnt_q[0]),
    .right_addr (cnt_q[1]),
    .left_data  (left_rd),
    .right_data (ins)
  );

  assign bus_out = rd_en ? left_rd : '0;
  assign ar_addr = cnt_q[0];
  assign pc_addr = cnt_q[1];

  // R5: idle read port drives zero
  p_idle_bus_r5: assert property (@(posedge clk) disable iff (!clr_n)
    !rd_en |-> bus_out == 8'h00);
  // R3: an unqualified load leaves the fetch pointer alone
  p_gated_load_r3: assert property (@(posedge clk) disable iff (!clr_n)
    (!bus_src_en && !pc_step) |=> $stable(pc_addr));
endmodule

// File: tb/twin_port_mem_test.sv
module twin_port_mem_test;
  logic       clk = 1'b0;
  logic       clr_n;
  logic [7:0] bus_in;
  logic       bus_src_en, ar_load, pc_load, ar_step, pc_step, mem_wr, rd_en;
  logic [7:0] bus_out, ins, ar_addr, pc_addr;
  int n_chk = 0;
  int n_bad = 0;

  twin_port_mem uut (
    .clk(clk), .clr_n(clr_n), .bus_in(bus_in), .bus_src_en(bus_src_en),
    .ar_load(ar_load), .pc_load(pc_load), .ar_step(ar_step), .pc_step(pc_step),
    .mem_wr(mem_wr), .rd_en(rd_en), .bus_out(bus_out), .ins(ins),
    .ar_addr(ar_addr), .pc_addr(pc_addr)
  );

  always #4 clk = ~clk;  // 125 MHz

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic idle();
    bus_in = 8'h00; bus_src_en = 0; ar_load = 0; pc_load = 0;
    ar_step = 0; pc_step = 0; mem_wr = 0; rd_en = 0;
  endtask

  // one edge: inputs set at negedge, results sampled at next negedge
  task automatic tick();
    @(posedge clk); @(negedge clk); #1;
  endtask

  task automatic load_ar(input logic [7:0] a);
    idle(); bus_in = a; bus_src_en = 1; ar_load = 1; tick(); idle();
  endtask
  task automatic load_pc(input logic [7:0] a);
    idle(); bus_in = a; bus_src_en = 1; pc_load = 1; tick(); idle();
  endtask
  task automatic write_at(input logic [7:0] a, input logic [7:0] d);
    load_ar(a); bus_in = d; mem_wr = 1; tick(); idle();
  endtask

  task automatic t_reset();
    idle(); clr_n = 0; #3;
    check("R1 ar cleared", ar_addr, 8'h00);
    check("R1 pc cleared", pc_addr, 8'h00);
    check("R5 idle bus", bus_out, 8'h00);
    @(negedge clk); clr_n = 1; #1;
  endtask

  task automatic t_write_read();
    write_at(8'h01, 8'h11);
    write_at(8'h02, 8'h22);
    load_ar(8'h01); rd_en = 1; #1;
    check("R4/R5 left read 01", bus_out, 8'h11);
    rd_en = 0; #1;
    check("R5 bus idle when rd_en low", bus_out, 8'h00);
    load_ar(8'h02); rd_en = 1; #1;
    check("R5 left read 02", bus_out, 8'h22);
    idle();
    load_pc(8'h01); check("R2 pc load", pc_addr, 8'h01);
    check("R6 right read 01", ins, 8'h11);
    load_pc(8'h02); check("R6 right read 02", ins, 8'h22);
  endtask

  task automatic t_gated_load();
    load_ar(8'h40);
    bus_in = 8'h99; ar_load = 1; pc_load = 1; tick(); idle();
    check("R3 ar holds without bus_src_en", ar_addr, 8'h40);
    check("R3 pc holds without bus_src_en", pc_addr, 8'h02);
  endtask

  task automatic t_stream();
    load_ar(8'h01); rd_en = 1; #1;
    check("R7 stream read first", bus_out, 8'h11);
    ar_step = 1; tick(); ar_step = 0; #1;
    check("R7 stream read second", bus_out, 8'h22);
    idle();
    load_pc(8'h01); pc_step = 1; tick(); idle();
    check("R7 pc step", pc_addr, 8'h02);
    check("R7 pc stream read", ins, 8'h22);
  endtask

  task automatic t_wrap();
    load_ar(8'hFF); ar_step = 1; tick(); idle();
    check("R7 ar wrap", ar_addr, 8'h00);
    load_pc(8'hFF); pc_step = 1; tick(); idle();
    check("R7 pc wrap", pc_addr, 8'h00);
  endtask

  task automatic t_priority();
    load_ar(8'h10);
    bus_in = 8'h30; bus_src_en = 1; ar_load = 1; ar_step = 1; tick(); idle();
    check("R8 ar load beats step", ar_addr, 8'h30);
    bus_in = 8'h50; bus_src_en = 1; pc_load = 1; pc_step = 1; tick(); idle();
    check("R8 pc load beats step", pc_addr, 8'h50);
  endtask

  task automatic t_collision();
    write_at(8'h60, 8'hA5);
    load_pc(8'h60);
    check("R9 initial content", ins, 8'hA5);
    load_ar(8'h60);
    bus_in = 8'h3C; mem_wr = 1; #1;
    check("R9 old data before edge", ins, 8'hA5);
    tick(); idle();
    check("R9 new data after edge", ins, 8'h3C);
  endtask

  task automatic t_write_step();
    load_ar(8'h70);
    bus_in = 8'h77; mem_wr = 1; ar_step = 1; tick(); idle();
    check("R10 ar advanced", ar_addr, 8'h71);
    load_pc(8'h70);
    check("R10 write at pre-increment address", ins, 8'h77);
  endtask

  task automatic t_async_clear();
    load_ar(8'h5A); load_pc(8'hA5);
    #1 clr_n = 0; #1;
    check("R1 ar cleared between edges", ar_addr, 8'h00);
    check("R1 pc cleared between edges", pc_addr, 8'h00);
    @(negedge clk); clr_n = 1; #1;
  endtask

  initial begin
    #200000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    clr_n = 1; idle();
    @(negedge clk);
    t_reset();
    t_write_read();
    t_gated_load();
    t_stream();
    t_wrap();
    t_priority();
    t_collision();
    t_write_step();
    t_async_clear();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule